// File: doc/BRIEF.md
# Parallel-Probe Key-Value Lookup Table

This block is a small on-chip associative table of fixed size. Storage is arranged as `BUCKETS` rows. Each row has `LINKS` slots, and every slot holds a key, a value and an occupied flag. A request carries a key. The key modulo `BUCKETS` picks one row. Every slot of that row then compares its key with the request key in the same cycle, and each slot produces one match bit.

On a lookup, each slot passes its value if it matches and zero if it does not. The row result is the bitwise OR of those per-slot values. A separate hit flag tells a stored zero apart from an absent key.

An insert goes to the hashed row:

- If a slot already holds the same key, the insert overwrites that slot's value.
- Otherwise the insert takes the lowest-numbered free slot.
- If the row has no free slot and no matching key, the insert is refused and a full flag is returned.

Requests use a valid/ready handshake. Every accepted request gets exactly one registered response on the next clock edge. A response is held until the consumer accepts it.

Top module: `kv_probe_table`

## Requirements
- R1: After reset, `rspValid` is 0, `reqReady` is 1, and every slot is free, so every lookup misses.
- R2: The row is selected by key modulo `BUCKETS`. A full row does not stop inserts into other rows.
- R3: A request is accepted on a rising edge where `reqValid` and `reqReady` are both 1. `rspValid` is 1 after that edge. When the response is taken and no new request is accepted, `rspValid` is 0 after the next edge.
- R4: A lookup (`reqWrite`=0) of a stored key returns `rspHit`=1 and `rspData` equal to the stored value.
- R5: A lookup of an absent key returns `rspHit`=0 and `rspData`=0. A key stored with value 0 returns `rspHit`=1 and `rspData`=0.
- R6: An insert (`reqWrite`=1) of a key already in its row replaces the value and returns `rspHit`=1 and `rspFull`=0.
- R7: An insert of a new key into a row with a free slot fills the lowest-numbered free slot and returns `rspHit`=0 and `rspFull`=0. Insert responses always carry `rspData`=0.
- R8: An insert of a new key into a full row changes nothing and returns `rspFull`=1 and `rspHit`=0. Keys already in that row remain readable, and the refused key still misses.
- R9: `reqReady` = !`rspValid` || `rspReady`. While `rspValid`=1 and `rspReady`=0, the response outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted |
| reqWrite | input | 1 | 1 = insert, 0 = lookup |
| reqKey | input | KEY_W | Request key |
| reqVal | input | VAL_W | Value for an insert |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Consumer accepts the response |
| rspHit | output | 1 | Key found (lookup) or overwritten (insert) |
| rspFull | output | 1 | Insert refused because the row is full |
| rspData | output | VAL_W | Lookup value; 0 on miss or insert |

## Verification
The bench uses the default build: `BUCKETS`=3, `LINKS`=2, and 8-bit keys and values. Three rows is not a power of two, so the hash must use a true modulo rather than low key bits. Keys 5, 8 and 11 all fall into row 2, which fills that row after two inserts and exposes both refusal and overwrite. Keys 3 and 4 land in the other rows and show that those rows stay independent of the full one.

// File: rtl/kvp_pkg.sv
package kvp_pkg;

  typedef struct packed {
    logic capture;
    logic isInsert;
    logic writeEn;
  } kvpStrobe_t;

endpackage

// File: rtl/kvp_ctrl.sv
module kvp_ctrl
  import kvp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       rspReady,
  input  logic       matchAny,
  input  logic       rowFull,
  output logic       reqReady,
  output logic       rspValid,
  output kvpStrobe_t strobe
);

  logic accept;

  assign reqReady = !rspValid || rspReady;
  assign accept   = reqValid && reqReady;

  always_comb begin
    strobe          = '0;
    strobe.capture  = accept;
    strobe.isInsert = reqWrite;
    strobe.writeEn  = accept && reqWrite && (matchAny || !rowFull);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
    end else if (accept) begin
      rspValid <= 1'b1;
    end else if (rspReady) begin
      rspValid <= 1'b0;
    end
  end

endmodule

// File: rtl/kvp_datapath.sv
module kvp_datapath
  import kvp_pkg::*;
#(
  parameter int KEY_W   = 8,
  parameter int VAL_W   = 8,
  parameter int BUCKETS = 3,
  parameter int LINKS   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  kvpStrobe_t       strobe,
  input  logic [KEY_W-1:0] reqKey,
  input  logic [VAL_W-1:0] reqVal,
  output logic             matchAny,
  output logic             rowFull,
  output logic             rspHit,
  output logic             rspFull,
  output logic [VAL_W-1:0] rspData
);

  localparam int BKT_W  = (BUCKETS > 1) ? $clog2(BUCKETS) : 1;
  localparam int LINK_W = (LINKS > 1) ? $clog2(LINKS) : 1;

  logic [KEY_W-1:0] keyMem   [BUCKETS][LINKS];
  logic [VAL_W-1:0] valMem   [BUCKETS][LINKS];
  logic             validMem [BUCKETS][LINKS];

  logic [BKT_W-1:0]  rowIdx;
  logic [LINKS-1:0]  slotMatch;
  logic [LINKS-1:0]  slotValid;
  logic [VAL_W-1:0]  slotMasked [LINKS];
  logic [VAL_W-1:0]  orValue;
  logic [LINK_W-1:0] matchIdx;
  logic [LINK_W-1:0] freeIdx;
  logic [LINK_W-1:0] wrSlot;

  // Row select: key modulo bucket count.
  assign rowIdx = BKT_W'(reqKey % KEY_W'(BUCKETS));

  // Compare every slot of the selected row at once, and mask the
  // values of the slots that do not match.
  for (genvar l = 0; l < LINKS; l++) begin : g_probe
    assign slotValid[l]  = validMem[rowIdx][l];
    assign slotMatch[l]  = slotValid[l] && (keyMem[rowIdx][l] == reqKey);
    assign slotMasked[l] = slotMatch[l] ? valMem[rowIdx][l] : '0;
  end

  always_comb begin
    orValue = '0;
    for (int l = 0; l < LINKS; l++) begin
      orValue = orValue | slotMasked[l];
    end
  end

  assign matchAny = |slotMatch;
  assign rowFull  = &slotValid;

  // Slot indices: the matching slot, and the lowest free slot.
  always_comb begin
    matchIdx = '0;
    freeIdx  = '0;
    for (int l = LINKS - 1; l >= 0; l--) begin
      if (slotMatch[l]) matchIdx = LINK_W'(l);
      if (!slotValid[l]) freeIdx = LINK_W'(l);
    end
  end

  assign wrSlot = matchAny ? matchIdx : freeIdx;

  for (genvar b = 0; b < BUCKETS; b++) begin : g_row
    for (genvar l = 0; l < LINKS; l++) begin : g_slot
      logic hitThis;
      assign hitThis = strobe.writeEn && (rowIdx == BKT_W'(b)) && (wrSlot == LINK_W'(l));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          validMem[b][l] <= 1'b0;
        end else if (hitThis) begin
          validMem[b][l] <= 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (hitThis) begin
          keyMem[b][l] <= reqKey;
          valMem[b][l] <= reqVal;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspHit  <= 1'b0;
      rspFull <= 1'b0;
      rspData <= '0;
    end else if (strobe.capture) begin
      rspHit  <= matchAny;
      rspFull <= strobe.isInsert && !matchAny && rowFull;
      rspData <= strobe.isInsert ? '0 : orValue;
    end
  end

endmodule

// File: rtl/kv_probe_table.sv
module kv_probe_table
  import kvp_pkg::*;
#(
  parameter int KEY_W   = 8,
  parameter int VAL_W   = 8,
  parameter int BUCKETS = 3,
  parameter int LINKS   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [KEY_W-1:0] reqKey,
  input  logic [VAL_W-1:0] reqVal,
  output logic             rspValid,
  input  logic             rspReady,
  output logic             rspHit,
  output logic             rspFull,
  output logic [VAL_W-1:0] rspData
);

  kvpStrobe_t strobe;
  logic       matchAny;
  logic       rowFull;

  kvp_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .rspReady (rspReady),
    .matchAny (matchAny),
    .rowFull  (rowFull),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  kvp_datapath #(
    .KEY_W   (KEY_W),
    .VAL_W   (VAL_W),
    .BUCKETS (BUCKETS),
    .LINKS   (LINKS)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqKey   (reqKey),
    .reqVal   (reqVal),
    .matchAny (matchAny),
    .rowFull  (rowFull),
    .rspHit   (rspHit),
    .rspFull  (rspFull),
    .rspData  (rspData)
  );

endmodule

// File: rtl/kvp_checker.sv
module kvp_checker #(
  parameter int VAL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             rspValid,
  input logic             rspReady,
  input logic             rspHit,
  input logic             rspFull,
  input logic [VAL_W-1:0] rspData
);

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid); // R3

  AST_RSP_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspReady && !(reqValid && reqReady)) |=> !rspValid); // R3

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspData) && $stable(rspHit) && $stable(rspFull))); // R9

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspData == '0)); // R5

  AST_FULL_NOT_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFull) |-> !rspHit); // R8

endmodule

bind kv_probe_table kvp_checker #(.VAL_W(VAL_W)) i_kvpChecker (.*);

// File: tb/test_kv_probe_table.sv
module test_kv_probe_table;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 15;

  // {write, key[7:0], val[7:0], expHit, expFull, expData[7:0]}
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b0, 8'd5,  8'h00, 1'b0, 1'b0, 8'h00},  // R1 R5 empty miss
    {1'b1, 8'd5,  8'h11, 1'b0, 1'b0, 8'h00},  // R7 new key row2
    {1'b0, 8'd5,  8'h00, 1'b1, 1'b0, 8'h11},  // R4
    {1'b1, 8'd8,  8'h22, 1'b0, 1'b0, 8'h00},  // R7 second slot row2
    {1'b1, 8'd11, 8'h33, 1'b0, 1'b1, 8'h00},  // R8 row2 full
    {1'b0, 8'd11, 8'h00, 1'b0, 1'b0, 8'h00},  // R8 refused key misses
    {1'b0, 8'd8,  8'h00, 1'b1, 1'b0, 8'h22},  // R8 old key kept
    {1'b1, 8'd5,  8'h44, 1'b1, 1'b0, 8'h00},  // R6 overwrite in full row
    {1'b0, 8'd5,  8'h00, 1'b1, 1'b0, 8'h44},  // R6 new value
    {1'b1, 8'd3,  8'h00, 1'b0, 1'b0, 8'h00},  // R7 row0 zero value
    {1'b0, 8'd3,  8'h00, 1'b1, 1'b0, 8'h00},  // R5 stored zero is a hit
    {1'b0, 8'd6,  8'h00, 1'b0, 1'b0, 8'h00},  // R2 same row, other key
    {1'b1, 8'd4,  8'h55, 1'b0, 1'b0, 8'h00},  // R2 row1 free despite row2 full
    {1'b0, 8'd4,  8'h00, 1'b1, 1'b0, 8'h55},  // R2
    {1'b0, 8'd14, 8'h00, 1'b0, 1'b0, 8'h00}   // R5 row2 miss
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic       reqWrite = 1'b0;
  logic [7:0] reqKey = '0;
  logic [7:0] reqVal = '0;
  logic       rspValid;
  logic       rspReady = 1'b1;
  logic       rspHit;
  logic       rspFull;
  logic [7:0] rspData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  kv_probe_table i_kv_probe_table (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .reqWrite (reqWrite),
    .reqKey   (reqKey),
    .reqVal   (reqVal),
    .rspValid (rspValid),
    .rspReady (rspReady),
    .rspHit   (rspHit),
    .rspFull  (rspFull),
    .rspData  (rspData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; accepted at the next rising edge; sampled at the following falling edge.
  task automatic doReq(input logic w, input logic [7:0] k, input logic [7:0] v);
    reqValid = 1'b1;
    reqWrite = w;
    reqKey   = k;
    reqVal   = v;
    @(posedge clk);
    #1 reqValid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rspValid after reset", 32'(rspValid), 32'd0);
    chk("R1 reqReady after reset", 32'(reqReady), 32'd1);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      doReq(VEC[i][26], VEC[i][25:18], VEC[i][17:10]);
      chk($sformatf("R3 vec%0d rspValid", i), 32'(rspValid), 32'd1);
      chk($sformatf("R4-tbl vec%0d hit", i), 32'(rspHit), 32'(VEC[i][9]));
      chk($sformatf("R8-tbl vec%0d full", i), 32'(rspFull), 32'(VEC[i][8]));
      chk($sformatf("R5-tbl vec%0d data", i), 32'(rspData), 32'(VEC[i][7:0]));
    end

    // R3: response retires with no new request
    @(negedge clk);
    chk("R3 rspValid drops", 32'(rspValid), 32'd0);

    // R9: stall holds the response and blocks new requests
    rspReady = 1'b0;
    doReq(1'b0, 8'd5, 8'h00);
    chk("R9 stalled data", 32'(rspData), 32'h44);
    chk("R9 reqReady low", 32'(reqReady), 32'd0);
    reqValid = 1'b1;
    reqWrite = 1'b0;
    reqKey   = 8'd8;
    @(negedge clk);
    chk("R9 held data", 32'(rspData), 32'h44);
    chk("R9 held valid", 32'(rspValid), 32'd1);
    rspReady = 1'b1;
    @(posedge clk);
    #1 reqValid = 1'b0;
    @(negedge clk);
    chk("R9 next response", 32'(rspData), 32'h22);
    chk("R9 next hit", 32'(rspHit), 32'd1);

    // R1: mid-run reset empties the table
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    doReq(1'b0, 8'd5, 8'h00);
    chk("R1 lookup after reset hit", 32'(rspHit), 32'd0);
    chk("R1 lookup after reset data", 32'(rspData), 32'd0);
    // R8 follow-on: row2 accepts two new keys again
    doReq(1'b1, 8'd11, 8'h66);
    chk("R7 insert after reset full", 32'(rspFull), 32'd0);
    doReq(1'b0, 8'd11, 8'h00);
    chk("R4 lookup after reinsertion", 32'(rspData), 32'h66);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule